// File: doc/BRIEF.md
# Shift-and-Saturate Execution Unit

This unit executes the scalar signed and unsigned saturate operations of a 32-bit processor pipeline. Each cycle it may accept one instruction word together with the value already read for its source register. It decodes the shift and width fields from the word, shifts the operand, and clamps the shifted value into a range whose width the instruction selects. One clock later it presents the result, the destination register index and a write strobe to the register file. A sticky overflow flag records every clamp.

Operand fetch, evaluation of the condition code against the status flags, and program-counter advance are handled by the surrounding pipeline. The unit only sees the outcome of the condition test, on `cond_pass`. The `is_unsigned` input comes from the pipeline's opcode decode and selects between the two clamp kinds. Halfword-pair saturation is not handled here.

Top module: `shift_sat_unit`

## Requirements
- R1: `src_idx` is combinationally `instr[3:0]`. After an executed operation, `dst_idx` holds that operation's `instr[15:12]`.
- R2: When `instr[6]` is 0, the operand is shifted left by `instr[11:7]`. Bits moved past bit 31 are lost before the clamp is applied.
- R3: When `instr[6]` is 1, the operand is shifted arithmetically right by `instr[11:7]`. A zero amount means a shift by 32, so every bit becomes a copy of bit 31.
- R4: With `is_unsigned` 0 and n = `instr[20:16]`, the shifted value (taken as signed) is clamped to the range from -2^n to 2^n-1. Values inside that range pass through unchanged.
- R5: With `is_unsigned` 1, a negative shifted value becomes 0, and a value above 2^n-1 becomes 2^n-1. Other values pass through unchanged.
- R6: An operation executes when `valid_in` is 1 and either `instr[31:28]` equals 4'hE or `cond_pass` is 1. `wr_en` in the next cycle equals that execute decision.
- R7: When no operation executes, `result` and `dst_idx` keep their previous values and `q_flag` is not set.
- R8: An executed operation that clamps sets `q_flag` on the next edge. The flag then stays 1 until it is cleared.
- R9: `q_clear` clears `q_flag` on the next edge. If an executed clamp happens in the same cycle, the flag is set instead.
- R10: A synchronous `rst` drives `result`, `dst_idx`, `wr_en` and `q_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| operand | input | 32 | Value of the source register |
| cond_pass | input | 1 | Condition test outcome from the pipeline |
| is_unsigned | input | 1 | 1 selects the unsigned clamp, 0 the signed clamp |
| q_clear | input | 1 | Clears the sticky saturation flag |
| src_idx | output | 4 | Source register index for the read port |
| dst_idx | output | 4 | Destination register index, registered |
| result | output | 32 | Saturated result, registered |
| wr_en | output | 1 | Register-file write strobe |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
Directed cases cover several situations:
- values one step above and below each clamp bound, which separate a correct compare from an off-by-one compare;
- negative inputs to the unsigned clamp, which separate a sign test from a magnitude test;
- an arithmetic right shift with a zero amount on both signs, which exposes a design that reads the amount literally;
- a left shift that pushes set bits past bit 31, which shows whether truncation happens before the clamp.

Random words with random widths and shift amounts, mixed with operands biased toward extreme values, compare every executed result against a 64-bit reference model. Suppressed operations with a failing condition, idle cycles and clears that coincide with a clamp check that results are held and that the flag priority is correct.

// File: rtl/shift_sat_unit.sv
module shift_sat_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        valid_in,
  input  logic [31:0] instr,
  input  logic [31:0] operand,
  input  logic        cond_pass,
  input  logic        is_unsigned,
  input  logic        q_clear,
  output logic [3:0]  src_idx,
  output logic [3:0]  dst_idx,
  output logic [31:0] result,
  output logic        wr_en,
  output logic        q_flag
);
  localparam logic [3:0] COND_ALWAYS = 4'hE;

  logic [4:0]  sh_amt, asr_amt, width_n;
  logic        is_asr, exec;
  logic [31:0] shifted, limit, top;
  logic        s_hi, s_lo, u_lo, u_hi, sat;
  logic [31:0] clamped;

  assign src_idx = instr[3:0];
  assign sh_amt  = instr[11:7];
  assign is_asr  = instr[6];
  assign width_n = instr[20:16];
  assign asr_amt = (sh_amt == 5'd0) ? 5'd31 : sh_amt;

  assign shifted = is_asr ? 32'($signed(operand) >>> asr_amt) : (operand << sh_amt);
  assign limit   = (32'd1 << width_n) - 32'd1;
  assign top     = 32'($signed(shifted) >>> width_n);

  assign s_hi = !top[31] && (top != 32'd0);
  assign s_lo = top[31] && (top != 32'hFFFF_FFFF);
  assign u_lo = shifted[31];
  assign u_hi = !shifted[31] && (shifted > limit);

  assign sat = is_unsigned ? (u_lo | u_hi) : (s_hi | s_lo);

  always_comb begin
    clamped = shifted;
    if (is_unsigned) begin
      if (u_lo)      clamped = 32'd0;
      else if (u_hi) clamped = limit;
    end else begin
      if (s_hi)      clamped = limit;
      else if (s_lo) clamped = ~limit;
    end
  end

  assign exec = valid_in && ((instr[31:28] == COND_ALWAYS) || cond_pass);

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      dst_idx <= '0;
      wr_en   <= 1'b0;
      q_flag  <= 1'b0;
    end else begin
      wr_en <= exec;
      if (exec) begin
        result  <= clamped;
        dst_idx <= instr[15:12];
      end
      if (exec && sat)  q_flag <= 1'b1;
      else if (q_clear) q_flag <= 1'b0;
    end
  end
endmodule

module shift_sat_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        valid_in,
  input logic [31:0] instr,
  input logic        cond_pass,
  input logic        is_unsigned,
  input logic        q_clear,
  input logic [31:0] result,
  input logic        wr_en,
  input logic        q_flag
);
  function automatic logic [31:0] hmask(input logic [4:0] n);
    return ~((32'd1 << n) - 32'd1);
  endfunction

  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(valid_in)); // R6
  AST_COND_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (valid_in && instr[31:28] != 4'hE && !cond_pass) |=> !wr_en); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(result)); // R7
  AST_SIGNED_RANGE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !$past(is_unsigned)) |->
      (((result & hmask($past(instr[20:16]))) == 32'd0) ||
       ((result & hmask($past(instr[20:16]))) == hmask($past(instr[20:16]))))); // R4
  AST_UNSIGNED_RANGE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(is_unsigned)) |->
      ((result & hmask($past(instr[20:16]))) == 32'd0)); // R5
  AST_Q_STICKY: assert property (@(posedge clk) disable iff (rst)
    (q_flag && !q_clear) |=> q_flag); // R8
  AST_Q_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (q_clear && !valid_in) |=> !q_flag); // R9
  AST_Q_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(q_flag) |-> ($past(valid_in) && wr_en)); // R8
endmodule

bind shift_sat_unit shift_sat_unit_chk u_chk (.*);

// File: tb/tb_shift_sat_unit.sv
module tb_shift_sat_unit;
  logic        clk = 1'b0;
  logic        rst, valid_in, cond_pass, is_unsigned, q_clear;
  logic [31:0] instr, operand;
  logic [3:0]  src_idx, dst_idx;
  logic [31:0] result;
  logic        wr_en, q_flag;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_res = '0;
  logic [3:0]  exp_dst = '0;
  logic        exp_q = 1'b0;

  always #2 clk = ~clk;

  shift_sat_unit dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] cond, input logic [4:0] n, input logic [3:0] rd,
                                     input logic [4:0] amt, input logic asr, input logic [3:0] rn);
    return {cond, 7'b0110101, n, rd, amt, asr, 2'b01, rn};
  endfunction

  function automatic logic [32:0] ref_op(input logic [31:0] ins, input logic [31:0] op, input logic uns);
    longint v, hi, lo;
    int a, n;
    logic s;
    a = int'(ins[11:7]);
    n = int'(ins[20:16]);
    if (ins[6]) begin
      if (a == 0) a = 32;
      v = longint'($signed(op)) >>> a;
    end else begin
      v = longint'($signed(32'(op << a)));
    end
    hi = (64'sd1 <<< n) - 1;
    lo = uns ? 64'sd0 : -(64'sd1 <<< n);
    s = 1'b0;
    if (v > hi) begin v = hi; s = 1'b1; end
    else if (v < lo) begin v = lo; s = 1'b1; end
    return {s, v[31:0]};
  endfunction

  task automatic run(input logic [31:0] ins, input logic [31:0] op, input logic uns,
                     input logic cp, input logic vld, input logic clr);
    logic [32:0] r;
    logic ex;
    @(negedge clk);
    instr = ins; operand = op; is_unsigned = uns; cond_pass = cp; valid_in = vld; q_clear = clr;
    #1;
    chk(src_idx == ins[3:0], "R1", {28'd0, src_idx}, {28'd0, ins[3:0]});
    r = ref_op(ins, op, uns);
    ex = vld && (ins[31:28] == 4'hE || cp);
    if (ex) begin exp_res = r[31:0]; exp_dst = ins[15:12]; end
    if (ex && r[32]) exp_q = 1'b1;
    else if (clr) exp_q = 1'b0;
    @(posedge clk);
    #1;
    chk(wr_en == ex, "R6", {31'd0, wr_en}, {31'd0, ex});
    chk(result == exp_res, ex ? (ins[6] ? "R3" : (uns ? "R5" : "R4")) : "R7", result, exp_res);
    chk(dst_idx == exp_dst, ex ? "R1" : "R7", {28'd0, dst_idx}, {28'd0, exp_dst});
    chk(q_flag == exp_q, clr ? "R9" : "R8", {31'd0, q_flag}, {31'd0, exp_q});
    valid_in = 1'b0; q_clear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    rst = 1'b1; valid_in = 1'b0; instr = '0; operand = '0;
    cond_pass = 1'b0; is_unsigned = 1'b0; q_clear = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(result == 0 && dst_idx == 0 && !wr_en && !q_flag, "R10", result, 32'd0);
    @(negedge clk); rst = 1'b0;

    run(mk(4'hE, 5'd7, 4'd3, 5'd0, 1'b0, 4'd1), 32'd200, 1'b0, 1'b0, 1'b1, 1'b0);           // R4 high
    run(mk(4'hE, 5'd0, 4'd4, 5'd0, 1'b0, 4'd1), 32'd0, 1'b0, 1'b0, 1'b1, 1'b1);             // R9 clear
    run(mk(4'hE, 5'd7, 4'd4, 5'd0, 1'b0, 4'd2), -32'sd300, 1'b0, 1'b0, 1'b1, 1'b0);         // R4 low
    run(mk(4'hE, 5'd7, 4'd4, 5'd0, 1'b0, 4'd2), 32'd127, 1'b0, 1'b0, 1'b1, 1'b1);           // R4 edge, R9
    run(mk(4'hE, 5'd7, 4'd4, 5'd0, 1'b0, 4'd2), -32'sd128, 1'b0, 1'b0, 1'b1, 1'b0);         // R4 edge
    run(mk(4'hE, 5'd0, 4'd5, 5'd0, 1'b1, 4'd6), 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b0);     // R3 amount 0
    run(mk(4'hE, 5'd3, 4'd5, 5'd0, 1'b1, 4'd6), 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0);     // R3 amount 0
    run(mk(4'hE, 5'd31, 4'd6, 5'd4, 1'b0, 4'd7), 32'h1000_0001, 1'b0, 1'b0, 1'b1, 1'b0);    // R2 truncation
    run(mk(4'hE, 5'd8, 4'd7, 5'd0, 1'b0, 4'd8), -32'sd5, 1'b1, 1'b0, 1'b1, 1'b1);           // R5 neg, R9 set wins
    run(mk(4'hE, 5'd8, 4'd7, 5'd0, 1'b0, 4'd8), 32'd300, 1'b1, 1'b0, 1'b1, 1'b0);           // R5 high
    run(mk(4'hE, 5'd8, 4'd8, 5'd0, 1'b0, 4'd8), 32'd255, 1'b1, 1'b0, 1'b1, 1'b1);           // R5 edge
    run(mk(4'h0, 5'd1, 4'd9, 5'd0, 1'b0, 4'd8), 32'd999, 1'b0, 1'b0, 1'b1, 1'b0);           // R6 R7 suppressed
    run(mk(4'h0, 5'd1, 4'd9, 5'd0, 1'b0, 4'd8), 32'd999, 1'b0, 1'b1, 1'b1, 1'b0);           // R6 cond passes
    run(mk(4'hE, 5'd1, 4'd10, 5'd0, 1'b0, 4'd8), 32'd999, 1'b0, 1'b0, 1'b0, 1'b0);          // R7 idle
    run(mk(4'hE, 5'd31, 4'd11, 5'd31, 1'b1, 4'd8), 32'h8000_0000, 1'b1, 1'b0, 1'b1, 1'b1);  // R3 R5

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ins, op;
      logic [3:0] cd;
      ins = $urandom;
      cd = ($urandom % 3 == 0) ? 4'($urandom) : 4'hE;
      ins[31:28] = cd;
      case ($urandom % 4)
        0: op = 32'h8000_0000 | ($urandom % 16);
        1: op = 32'h7FFF_FFF0 | ($urandom % 16);
        2: op = $urandom % 512 - 256;
        default: op = $urandom;
      endcase
      run(ins, op, 1'($urandom), 1'($urandom), ($urandom % 8) != 0, ($urandom % 6) == 0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule